// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous static RAM with a 19-bit address and a byte-wide data bus. The host offers one access at a time through a request/ready handshake. The controller then produces the memory's active-low chip-select, output-enable and write-enable strobes. It also produces a split data bus: a value to drive, a drive enable, and a sampled input. A read returns the byte to the host with a one-cycle valid pulse.

Each phase length is a whole number of clocks. It is derived from a clock-period parameter and the memory's minimum timing numbers: the ceiling of the time divided by the period, never below one. With the default 10 ns clock, a read holds its strobes for 2 cycles and a write pulse lasts 2 cycles. The turnaround after a read is 1 cycle. Writes keep output-enable high for their whole length, so the memory never drives the bus during a write. The address moves only while chip-select and write-enable are both high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, cs_n, oe_n and we_n are 1, dq_drive is 0, rdata_valid is 0. Once reset is released, host_ready is 1.
- R2: A read holds cs_n and oe_n low together, with we_n high, for exactly max(1, ceil(max(20, 20, 20, 8) ns / CLK_PERIOD_NS)) consecutive cycles. This is 2 cycles at 10 ns.
- R3: The byte present on dq_in in the last cycle of the read strobe is returned on host_rdata. rdata_valid is 1 for exactly one cycle, the cycle after the strobes end.
- R4: A write holds cs_n and we_n low together for exactly max(1, ceil(max(20, 16, 16, 11, 9) ns / CLK_PERIOD_NS)) cycles. This is 2 cycles at 10 ns. oe_n stays 1 for the whole write, and the byte lands at the requested address.
- R5: dq_drive is 1 in every cycle where we_n is 0 and in the one cycle after the pulse. It is never 1 while oe_n is 0, and never 1 at any other time.
- R6: mem_addr changes only in a cycle that follows one where cs_n and we_n were both 1. It is stable for as long as cs_n stays low.
- R7: After a read, at least max(1, ceil(8 ns / CLK_PERIOD_NS)) cycles pass with oe_n high before dq_drive can rise. host_ready is 0 during that turnaround.
- R8: A request is taken only in a cycle where host_ready is 1. host_ready falls for the whole transaction. Request, flag, address and data changes while host_ready is 0 have no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Controller idle, request will be taken |
| host_rdata | output | 8 | Read byte |
| rdata_valid | output | 1 | One-cycle pulse marking host_rdata |
| mem_addr | output | 19 | Memory address |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | 8 | Byte to drive on the memory bus |
| dq_drive | output | 1 | Enable for the bus driver |
| dq_in | input | 8 | Byte sampled from the memory bus |

## Verification
The bench's memory model returns unknown data until the read strobe has been low for the full access time. A controller that samples one edge early therefore returns X instead of the stored byte. Every address pattern of a 1024-entry sweep is written and then read back, covering address 0 and the all-ones address. Repeating the upper address bits catches crossed or dropped address lines. A read is followed at once by a write, so a missing turnaround shows up as the driver rising within the memory's float window. The bench also scrambles request, flag, address and data during every busy period. A controller that re-samples them would write extra pulses or write wrong bytes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // whole clocks covering a minimum time, at least one
    function automatic int unsigned phase_cycles(input int unsigned min_ns,
                                                 input int unsigned clk_ns);
        int unsigned c;
        c = (min_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned count_width(input int unsigned top);
        return (top < 2) ? 1 : $clog2(top + 1);
    endfunction

    function automatic strobe_t strobes_for(input ctl_state_e s);
        strobe_t r;
        r = STROBE_QUIET;
        case (s)
            ST_RD_ACC: begin
                r.cs_n = 1'b0;
                r.oe_n = 1'b0;
            end
            ST_WR_PULSE: begin
                r.cs_n  = 1'b0;
                r.we_n  = 1'b0;
                r.drive = 1'b1;
            end
            ST_WR_HOLD: r.drive = 1'b1;
            default: r = STROBE_QUIET;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CNT_W    = 2,
    parameter int unsigned RD_LEN   = 2,
    parameter int unsigned TURN_LEN = 1,
    parameter int unsigned WR_LEN   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output strobe_t          strb
);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_LEN - 1);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_LEN - 1);

    ctl_state_e state_q, state_d;
    strobe_t    strb_q;

    assign ready   = (state_q == ST_IDLE);
    assign accept  = ready && req;
    assign capture = (state_q == ST_RD_ACC) && tmr_done;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (req) state_d = wr ? ST_WR_SETUP : ST_RD_ACC;
            ST_RD_ACC:   if (tmr_done) state_d = ST_RD_TURN;
            ST_RD_TURN:  if (tmr_done) state_d = ST_IDLE;
            ST_WR_SETUP: state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept && !wr) begin
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
        end else if (capture) begin
            tmr_load = 1'b1;
            tmr_val  = TURN_LOAD;
        end else if (state_q == ST_WR_SETUP) begin
            tmr_load = 1'b1;
            tmr_val  = WR_LOAD;
        end
    end

    // strobes come straight from flops, aligned with the state
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            strb_q  <= STROBE_QUIET;
        end else begin
            state_q <= state_d;
            strb_q  <= strobes_for(state_d);
        end
    end

    assign strb = strb_q;
endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              wr,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= capture;
            if (accept) begin
                addr_q <= host_addr;
                if (wr) wdat_q <= host_wdata;
            end
            if (capture) rdat_q <= dq_in;
        end
    end

    assign mem_addr    = addr_q;
    assign dq_out      = wdat_q;
    assign rdata       = rdat_q;
    assign rdata_valid = vld_q;
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RC_NS       = 20,
    parameter int unsigned T_AA_NS       = 20,
    parameter int unsigned T_ACE_NS      = 20,
    parameter int unsigned T_OE_NS       = 8,
    parameter int unsigned T_HZ_NS       = 8,
    parameter int unsigned T_WC_NS       = 20,
    parameter int unsigned T_AW_NS       = 16,
    parameter int unsigned T_CW_NS       = 16,
    parameter int unsigned T_WP_NS       = 11,
    parameter int unsigned T_DW_NS       = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int unsigned RD_LEN = phase_cycles(
        max_u(max_u(T_RC_NS, T_AA_NS), max_u(T_ACE_NS, T_OE_NS)), CLK_PERIOD_NS);
    localparam int unsigned WR_LEN = phase_cycles(
        max_u(max_u(max_u(T_WC_NS, T_AW_NS), max_u(T_CW_NS, T_WP_NS)), T_DW_NS),
        CLK_PERIOD_NS);
    localparam int unsigned TURN_LEN = phase_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int unsigned CNT_W = count_width(max_u(max_u(RD_LEN, WR_LEN), TURN_LEN));

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;
    strobe_t          strb;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_fsm #(
        .CNT_W    (CNT_W),
        .RD_LEN   (RD_LEN),
        .TURN_LEN (TURN_LEN),
        .WR_LEN   (WR_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (host_req),
        .wr       (host_write),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .accept   (accept),
        .capture  (capture),
        .ready    (host_ready),
        .strb     (strb)
    );

    sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .wr          (host_write),
        .capture     (capture),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .dq_in       (dq_in),
        .mem_addr    (mem_addr),
        .dq_out      (dq_out),
        .rdata       (host_rdata),
        .rdata_valid (rdata_valid)
    );

    assign cs_n     = strb.cs_n;
    assign oe_n     = strb.oe_n;
    assign we_n     = strb.we_n;
    assign dq_drive = strb.drive;
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ready,
    input logic              rdata_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_drive
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (cs_n && oe_n && we_n && !dq_drive && !rdata_valid)); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid); // R3

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cs_n); // R4

    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> oe_n); // R4

    AST_DRIVE_NOT_WITH_OE: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> oe_n); // R5

    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_drive); // R5

    AST_ADDR_HELD_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> $stable(mem_addr)); // R6

    AST_ADDR_HELD_READ: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(mem_addr)); // R6

    AST_NO_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        $past(!oe_n) |-> !dq_drive); // R7

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (cs_n && oe_n && we_n && !dq_drive)); // R8
endmodule

bind sram_bus_ctrl sram_ctl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_ready  (host_ready),
    .rdata_valid (rdata_valid),
    .mem_addr    (mem_addr),
    .cs_n        (cs_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .dq_drive    (dq_drive)
);

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;
    localparam int CLK_NS   = 10;
    localparam int RD_LEN   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int WR_LEN   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int TURN_LEN = (8 + CLK_NS - 1) / CLK_NS;
    localparam int NWORDS   = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic        rdata_valid;
    logic [18:0] mem_addr;
    logic        cs_n, oe_n, we_n, dq_drive;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] model [NWORDS];
    logic [7:0] expect_mem [NWORDS];

    int rd_run = 0, last_rd_len = 0;
    int wr_run = 0, last_wr_len = 0, wr_pulses = 0;
    int since_oe = 1000, rd_age = 0;
    int bad_oe = 0, bad_drv = 0, bad_addr = 0, bad_map = 0;
    logic        prev_drive = 1'b0, prev_cs_n = 1'b1, prev_we_n = 1'b1;
    logic [18:0] prev_addr = '0;

    sram_bus_ctrl dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .rdata_valid(rdata_valid), .mem_addr(mem_addr),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .dq_out(dq_out),
        .dq_drive(dq_drive), .dq_in(dq_in)
    );

    always #(CLK_NS / 2) clk = ~clk;

    // memory model: data appears only after the full access time
    always_comb begin
        if (!cs_n && !oe_n && we_n && rd_age >= RD_LEN)
            dq_in = model[mem_addr[9:0]];
        else
            dq_in = 'x;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // protocol monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n && !oe_n) rd_run++;
            else if (rd_run != 0) begin last_rd_len = rd_run; rd_run = 0; end
            if (!cs_n && !we_n) wr_run++;
            else if (wr_run != 0) begin last_wr_len = wr_run; wr_run = 0; wr_pulses++; end
            if (!oe_n) since_oe = 0;
            else if (since_oe < 1000) since_oe++;
            if (dq_drive && !prev_drive)
                check(since_oe > TURN_LEN, "R7 oe-high cycles before drive", since_oe, TURN_LEN + 1);
            if (!we_n && !oe_n) bad_oe++;
            if (dq_drive && !oe_n) bad_drv++;
            if (!we_n && !dq_drive) bad_drv++;
            if (mem_addr != prev_addr &&
                ((!cs_n && !prev_cs_n) || !we_n || !prev_we_n)) bad_addr++;
            if (!cs_n && (mem_addr[18:10] != mem_addr[8:0])) bad_map++;
            if (!cs_n && !we_n) model[mem_addr[9:0]] = dq_out;
            if (!cs_n && !oe_n) rd_age++;
            else rd_age = 0;
            prev_drive = dq_drive;
            prev_cs_n  = cs_n;
            prev_we_n  = we_n;
            prev_addr  = mem_addr;
        end
    end

    function automatic logic [18:0] addr_of(input int i);
        return {i[8:0], i[9:0]};
    endfunction

    // hold the request until taken, then scramble inputs while busy
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        host_req   = 1'b1;
        host_write = wr;
        host_addr  = a;
        host_wdata = d;
        while (!host_ready) @(negedge clk);
        @(negedge clk);
        while (!host_ready) begin
            host_req   = 1'b1;
            host_write = $urandom_range(0, 1) != 0;
            host_addr  = 19'($urandom);
            host_wdata = 8'($urandom);
            @(negedge clk);
        end
        host_req = 1'b0;
    endtask

    task automatic do_write(input int i, input logic [7:0] d, input bit len_chk);
        expect_mem[i] = d;
        issue(1'b1, addr_of(i), d);
        #1;
        if (len_chk) check(last_wr_len == WR_LEN, "R4 write pulse length", last_wr_len, WR_LEN);
    endtask

    task automatic do_read(input int i, input bit len_chk);
        int vcycles;
        host_req   = 1'b1;
        host_write = 1'b0;
        host_addr  = addr_of(i);
        while (!host_ready) @(negedge clk);
        @(negedge clk);
        host_req = 1'b0;
        vcycles = 0;
        while (!rdata_valid && vcycles < 50) begin @(negedge clk); vcycles++; end
        check(host_rdata === expect_mem[i], "R3 read data", int'(host_rdata), int'(expect_mem[i]));
        if (len_chk) begin
            check(vcycles == RD_LEN, "R3 valid timing", vcycles, RD_LEN);
            check(!host_ready, "R7 ready low in turnaround", int'(host_ready), 0);
        end
        @(negedge clk);
        if (len_chk) check(!rdata_valid, "R3 valid one cycle", int'(rdata_valid), 0);
        while (!host_ready) @(negedge clk);
        #1;
        if (len_chk) check(last_rd_len == RD_LEN, "R2 read strobe length", last_rd_len, RD_LEN);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int writes_issued;
        for (int k = 0; k < NWORDS; k++) model[k] = 'x;
        repeat (3) @(negedge clk);
        check(cs_n && oe_n && we_n, "R1 strobes high in reset", {cs_n, oe_n, we_n}, 7);
        check(!dq_drive && !rdata_valid, "R1 driver and valid low in reset",
              {dq_drive, rdata_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(host_ready, "R1 ready after reset", int'(host_ready), 1);
        check(cs_n && oe_n && we_n && !dq_drive, "R1 quiet after reset",
              {cs_n, oe_n, we_n, dq_drive}, 14);

        writes_issued = 0;
        for (int i = 0; i < NWORDS; i++) begin
            do_write(i, 8'((i * 7 + 3) ^ (i >> 2)), i < 8 || i == NWORDS - 1);
            writes_issued++;
        end
        for (int i = 0; i < NWORDS; i++) do_read(i, i < 8 || i == NWORDS - 1);

        // read then write back-to-back, then overwrite checks
        for (int i = 0; i < 16; i++) begin
            do_read(i * 61 % NWORDS, 1'b1);
            do_write(i * 61 % NWORDS, 8'(255 - i), 1'b1);
            writes_issued++;
            do_read(i * 61 % NWORDS, 1'b1);
        end

        check(wr_pulses == writes_issued, "R8 one pulse per accepted write", wr_pulses, writes_issued);
        check(bad_oe == 0, "R4 oe_n high during write", bad_oe, 0);
        check(bad_map == 0, "R4 address routing", bad_map, 0);
        check(bad_drv == 0, "R5 driver window", bad_drv, 0);
        check(bad_addr == 0, "R6 address stable under strobes", bad_addr, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule